// File: doc/BRIEF.md
# Vector Immediate Pattern Generator

This block expands the 13-bit immediate field of a vector load-immediate operation into a full 128-bit register value. Bit 12 of the field picks one of two paths. The first path takes a short signed constant, sign-extends it, and repeats it across lanes of a chosen element width. The second path decodes a 4-bit mode. The mode selects one of thirteen 64-bit constant shapes built from a single byte: byte placement, halfword placement, shifted masks, a byte splat, per-bit byte masks and floating-point-style exponent expansions. That 64-bit shape is then written into both halves of the result.

A caller presents the immediate together with a valid strobe. One clock later the block returns the expanded value with a valid flag, a write enable and an illegal-operation flag. The flag is raised for the three mode codes that have no defined pattern. An illegal result carries all-zero data, and its write enable stays low, so a downstream register file never takes the value.

Top module: `vimm_expander`

## Requirements
- R1: `in_imm[12]` selects the path: 0 selects the signed splat, and 1 selects the mode pattern, whose element width is 64 bits.
- R2: On the splat path, `in_imm[9:0]` is sign-extended as a 10-bit value. `in_imm[11:10]` picks the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). The value, truncated to the lane width, fills every lane of `out_data`.
- R3: On the pattern path, `in_imm[11:8]` is the mode and `in_imm[7:0]` is the byte t. Modes 0, 1, 2 and 3 place t in byte 0, 1, 2 or 3 of every 32-bit word, and every other bit is zero.
- R4: Mode 4 puts t in the low byte of every 16-bit halfword. Mode 5 puts t in the high byte. The other byte is zero.
- R5: Mode 6 makes every 32-bit word 0x0000ttFF. Mode 7 makes every 32-bit word 0x00ttFFFF.
- R6: Mode 8 repeats t in all eight bytes of the pattern. Mode 9 sets byte i of the pattern to 0xFF when t[i] is 1 and to 0x00 when t[i] is 0.
- R7: Mode 10 makes every 32-bit word {t[7], ~t[6], 5 copies of t[6], t[5:0], 19 zeros}. Mode 11 puts that word in bits 31:0 of the pattern only, and bits 63:32 are zero.
- R8: Mode 12 makes the 64-bit pattern {t[7], ~t[6], 8 copies of t[6], t[5:0], 48 zeros}.
- R9: Modes 13, 14 and 15 raise `out_illegal`, force `out_data` to zero and hold `out_wen` low.
- R10: On the pattern path, `out_data[127:64]` equals `out_data[63:0]`.
- R11: Outputs appear one cycle after `in_valid` is high. `out_valid` is low in the cycle after `in_valid` is low. `out_wen` is `out_valid` and not `out_illegal`.
- R12: While `rst_n` is low, `out_valid`, `out_illegal` and `out_wen` are low.
- R13: The splat path never raises `out_illegal`, whatever the value of `in_imm[11:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Immediate is present this cycle |
| in_imm | input | 13 | Immediate field |
| out_valid | output | 1 | Result valid |
| out_wen | output | 1 | Write enable for the destination register |
| out_illegal | output | 1 | Undefined pattern mode |
| out_data | output | 128 | Expanded vector value |

## Verification
The hardest case to reach is a splat immediate whose bits 11:8 hold 13, 14 or 15. Those are the same bits that read as an undefined mode on the pattern path, so a decoder that looks at the mode before the path bit would wrongly flag them. The stimulus drives exactly these codes with bit 12 clear and then with it set, back to back. It also applies a reset in the middle of a stream and leaves gaps in the valid strobe, so the one-cycle pipeline and the flags are checked when they have to drop as well as rise.

// File: rtl/vimm_pkg.sv
package vimm_pkg;
  localparam int IMM_W  = 13;
  localparam int PAT_W  = 64;
  localparam int SPL_W  = 10;

  typedef enum logic [3:0] {
    PM_B0      = 4'd0,
    PM_B1      = 4'd1,
    PM_B2      = 4'd2,
    PM_B3      = 4'd3,
    PM_HLO     = 4'd4,
    PM_HHI     = 4'd5,
    PM_MSK8    = 4'd6,
    PM_MSK16   = 4'd7,
    PM_SPLAT   = 4'd8,
    PM_BITMASK = 4'd9,
    PM_F32X2   = 4'd10,
    PM_F32X1   = 4'd11,
    PM_F64     = 4'd12
  } pat_mode_e;
endpackage

// File: rtl/vimm_splat.sv
module vimm_splat #(
  parameter int DATA_W = 128,
  parameter int VAL_W  = 10
) (
  input  logic [VAL_W-1:0]  val,
  input  logic [1:0]        esize,
  output logic [DATA_W-1:0] dout
);
  localparam int N_SZ = 4;
  localparam int MAXW = 8 << (N_SZ - 1);

  logic [MAXW-1:0]   sx;
  logic [DATA_W-1:0] cand [N_SZ];

  assign sx = {{(MAXW-VAL_W){val[VAL_W-1]}}, val};

  for (genvar g = 0; g < N_SZ; g++) begin : g_size
    localparam int LW  = 8 << g;
    localparam int REP = DATA_W / LW;
    assign cand[g] = {REP{sx[LW-1:0]}};
  end

  assign dout = cand[esize];
endmodule

// File: rtl/vimm_pattern.sv
module vimm_pattern
  import vimm_pkg::*;
(
  input  logic [3:0]       mode,
  input  logic [7:0]       t,
  output logic [PAT_W-1:0] pat,
  output logic             illegal
);
  logic [31:0] f32;
  logic [63:0] f64;
  logic [63:0] bmask;

  assign f32 = {t[7], ~t[6], {5{t[6]}}, t[5:0], 19'b0};
  assign f64 = {t[7], ~t[6], {8{t[6]}}, t[5:0], 48'b0};

  for (genvar i = 0; i < 8; i++) begin : g_bm
    assign bmask[8*i +: 8] = {8{t[i]}};
  end

  always_comb begin
    illegal = 1'b0;
    pat     = '0;
    case (mode)
      PM_B0:      pat = {2{24'b0, t}};
      PM_B1:      pat = {2{16'b0, t, 8'b0}};
      PM_B2:      pat = {2{8'b0, t, 16'b0}};
      PM_B3:      pat = {2{t, 24'b0}};
      PM_HLO:     pat = {4{8'b0, t}};
      PM_HHI:     pat = {4{t, 8'b0}};
      PM_MSK8:    pat = {2{16'b0, t, 8'hFF}};
      PM_MSK16:   pat = {2{8'b0, t, 16'hFFFF}};
      PM_SPLAT:   pat = {8{t}};
      PM_BITMASK: pat = bmask;
      PM_F32X2:   pat = {2{f32}};
      PM_F32X1:   pat = {32'b0, f32};
      PM_F64:     pat = f64;
      default:    illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/vimm_expander.sv
module vimm_expander
  import vimm_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [12:0]       in_imm,
  output logic              out_valid,
  output logic              out_wen,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_data
);
  localparam int HALVES = DATA_W / PAT_W;

  logic              sel_pat;
  logic [DATA_W-1:0] splat_d;
  logic [PAT_W-1:0]  pat_d;
  logic              pat_ill;
  logic              ill_d;
  logic [DATA_W-1:0] data_d;
  logic              valid_q, illegal_q;
  logic [DATA_W-1:0] data_q;

  assign sel_pat = in_imm[12];

  vimm_splat #(.DATA_W(DATA_W), .VAL_W(SPL_W)) i_splat (
    .val   (in_imm[SPL_W-1:0]),
    .esize (in_imm[11:10]),
    .dout  (splat_d)
  );

  vimm_pattern i_pattern (
    .mode    (in_imm[11:8]),
    .t       (in_imm[7:0]),
    .pat     (pat_d),
    .illegal (pat_ill)
  );

  // next-state
  always_comb begin
    ill_d = sel_pat & pat_ill;
    if (ill_d)        data_d = '0;
    else if (sel_pat) data_d = {HALVES{pat_d}};
    else              data_d = splat_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= in_valid;
      illegal_q <= in_valid & ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) data_q <= data_d;
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_wen     = valid_q & ~illegal_q;
  assign out_data    = data_q;

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_wen);
  a_r9_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm[12] && in_imm[11:8] > 4'd12) |=> out_illegal && !out_wen && out_data == '0);
  a_r13_splat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_imm[12]) |=> !out_illegal && out_wen);
  a_r10_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm[12]) |=> out_data[DATA_W-1:PAT_W] == out_data[PAT_W-1:0]);
  a_r12_flags_low: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !out_illegal && !out_wen);
endmodule

// File: tb/test_vimm_expander.sv
module test_vimm_expander;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [12:0]  in_imm = '0;
  logic         out_valid, out_wen, out_illegal;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  logic         m_valid, m_ill;
  logic [127:0] m_data;
  logic [12:0]  m_imm;

  always #10 clk = ~clk;

  vimm_expander i_vimm_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_imm(in_imm),
    .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_data(out_data)
  );

  function automatic logic [127:0] ref_data(input logic [12:0] imm);
    logic [127:0] r;
    logic [63:0]  p;
    logic [63:0]  sv;
    logic [7:0]   t;
    logic [31:0]  w;
    int           lw;
    r  = '0;
    p  = '0;
    t  = imm[7:0];
    sv = {{54{imm[9]}}, imm[9:0]};
    if (!imm[12]) begin
      lw = 8 << imm[11:10];
      for (int i = 0; i < 128; i++) r[i] = sv[i % lw];
      return r;
    end
    w = 0;
    w[31] = t[7]; w[30] = ~t[6];
    for (int i = 25; i < 30; i++) w[i] = t[6];
    w[24:19] = t[5:0];
    case (imm[11:8])
      0, 1, 2, 3: for (int k = 0; k < 2; k++) p[32*k + 8*imm[9:8] +: 8] = t;
      4: for (int k = 0; k < 4; k++) p[16*k +: 8] = t;
      5: for (int k = 0; k < 4; k++) p[16*k + 8 +: 8] = t;
      6: for (int k = 0; k < 2; k++) p[32*k +: 32] = 32'h0000_00FF | (32'(t) << 8);
      7: for (int k = 0; k < 2; k++) p[32*k +: 32] = 32'h0000_FFFF | (32'(t) << 16);
      8: for (int k = 0; k < 8; k++) p[8*k +: 8] = t;
      9: for (int k = 0; k < 8; k++) p[8*k +: 8] = t[k] ? 8'hFF : 8'h00;
      10: p = {w, w};
      11: p = {32'b0, w};
      12: begin
        p[63] = t[7]; p[62] = ~t[6];
        for (int i = 54; i < 62; i++) p[i] = t[6];
        p[53:48] = t[5:0];
      end
      default: p = '0;
    endcase
    r = {p, p};
    return r;
  endfunction

  function automatic string tag_of(input logic [12:0] imm);
    if (!imm[12]) return "R1 R2";
    case (imm[11:8])
      0, 1, 2, 3: return "R1 R3 R10";
      4, 5:       return "R1 R4 R10";
      6, 7:       return "R1 R5 R10";
      8, 9:       return "R1 R6 R10";
      10, 11:     return "R1 R7 R10";
      12:         return "R1 R8 R10";
      default:    return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_ill   <= 1'b0;
    end else begin
      m_valid <= in_valid;
      m_ill   <= in_valid && in_imm[12] && in_imm[11:8] > 4'd12;
      if (in_valid) begin
        m_data <= ref_data(in_imm);
        m_imm  <= in_imm;
      end
    end
  end

  task automatic chk1(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk1("R11 valid", 128'(out_valid), 128'(m_valid));
    chk1((m_valid && !m_imm[12]) ? "R13 illegal" : "R9 illegal",
         128'(out_illegal), 128'(m_ill));
    chk1("R11 R9 wen", 128'(out_wen), 128'(m_valid && !m_ill));
    if (m_valid) chk1(tag_of(m_imm), out_data, m_data);
  endtask

  task automatic step(input logic v, input logic [12:0] imm);
    @(negedge clk);
    compare();
    in_valid = v;
    in_imm   = imm;
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk1("R12 reset valid", 128'(out_valid), 128'(0));
    chk1("R12 reset illegal", 128'(out_illegal), 128'(0));
    chk1("R12 reset wen", 128'(out_wen), 128'(0));
    rst_n = 1'b1;
    // splat, every width, edge values
    for (int s = 0; s < 4; s++) begin
      step(1'b1, {1'b0, 2'(s), 10'h1FF});
      step(1'b1, {1'b0, 2'(s), 10'h200});
      step(1'b1, {1'b0, 2'(s), 10'h3FF});
      step(1'b1, {1'b0, 2'(s), 10'h155});
      step(1'b1, {1'b0, 2'(s), 10'h000});
    end
    // every pattern mode with several bytes
    for (int m = 0; m < 16; m++) begin
      step(1'b1, {1'b1, 4'(m), 8'hA5});
      step(1'b1, {1'b1, 4'(m), 8'h40});
      step(1'b1, {1'b1, 4'(m), 8'h80});
      step(1'b0, {1'b1, 4'(m), 8'h3C});
      step(1'b1, {1'b1, 4'(m), 8'h7F});
    end
    // R13: splat with bits 11:8 looking like undefined modes, back to back with pattern
    for (int m = 13; m < 16; m++) begin
      step(1'b1, {1'b0, 4'(m), 8'h9B});
      step(1'b1, {1'b1, 4'(m), 8'h9B});
      step(1'b1, {1'b0, 4'(m), 8'h01});
    end
    // reset in the middle of a stream
    step(1'b1, {1'b1, 4'd14, 8'h11});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk1("R12 mid reset valid", 128'(out_valid), 128'(0));
    chk1("R12 mid reset illegal", 128'(out_illegal), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b0;
    // random stream
    for (int k = 0; k < 2000; k++) step(1'($urandom % 4 != 0), 13'($urandom));
    step(1'b0, '0);
    step(1'b0, '0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule